// File: doc/BRIEF.md
# Serializer Chain Readout and Fault Checker

This block reads a daisy chain of eight-input serializer devices in a single SPI burst. On a start request it drops chip select, clocks the whole chain (one byte per device in plain mode, two bytes per device in status mode), and splits the received bytes into one input byte and, when present, one status byte per device. Each device is judged on its own. The block checks the status byte's CRC-5, decodes the overtemperature and undervoltage flags, and combines them with that device's fault pin into a per-device faulting bit. A faulting device never hides the data of a healthy neighbour.

The result is a flat input vector of eight bits per device, with per-device flag vectors. These are updated together with a one-cycle done strobe. The block also holds the two debounce select outputs that are wired to the devices, either one pair per device or one pair shared by the chain.

The sequencer has five states: IDLE (waiting, chip select high), LEAD (chip select low, SCLK low for one half period), HIGH (SCLK high; the bit is captured on entry), LOW (SCLK low between bits) and EVAL (one cycle in which results are registered). The transitions are:
- IDLE to LEAD on start.
- LEAD to HIGH, and LOW to HIGH, at the end of a half period.
- HIGH to LOW at the end of a half period while bits remain.
- HIGH to EVAL at the end of a half period after the last bit.
- EVAL to IDLE unconditionally.

Top module: `chain_reader`

## Requirements
- R1: When `start_i` is high while `busy_o` is low, `cs_n_o` goes low and the block captures B bits from `miso_i`, one at each rising SCLK edge. B is 16·N_DEV when `wide_mode_i`=1 (status mode) and 8·N_DEV when it is 0 (plain mode). Each byte arrives MSB first, and byte 0 arrives first. `sclk_o` is low whenever `cs_n_o` is high, and `start_i` has no effect while `busy_o` is high.
- R2: Each SCLK half period lasts CLK_DIV cycles, and the first rising edge comes CLK_DIV cycles after `cs_n_o` falls. `cs_n_o` rises together with the last SCLK fall. `done_o` is a one-cycle pulse that goes high 2·B·CLK_DIV+1 clock edges after the edge that accepted the start.
- R3: The input byte of device i sits at byte offset i·W, where W=2 in status mode and W=1 in plain mode. In status mode the status byte of device i is the byte that follows it. Bit k of `in_vec_o` is bit (k mod 8) of the input byte of device k/8.
- R4: In status mode, `crc_err_o[i]` is 1 exactly when status bits [7:3] differ from the CRC-5 of the input byte. The CRC-5 uses generator x^5+x^4+x^2+1, is computed MSB first and starts from zero.
- R5: In status mode, `ot_o[i]` equals status bit 1, `uv_alarm_o[i]` is the inverse of status bit 2 and `uv_warn_o[i]` is the inverse of status bit 0. In plain mode `crc_err_o`, `ot_o`, `uv_alarm_o` and `uv_warn_o` are all zero.
- R6: With `ign_uv_i`=1, `uv_alarm_o` and `uv_warn_o` are zero and the fault pins do not affect `dev_bad_o`. The mode and ignore settings are latched when a start is accepted.
- R7: `dev_bad_o[i]` is 1 when device i's fault pin is high and undervoltage is not ignored. In status mode it is also 1 on a CRC error, on overtemperature, or on the undervoltage alarm. The undervoltage warning alone never sets it.
- R8: With FAULT_PER_DEV=0, `fault_pin_i` is one bit that applies to every device. With FAULT_PER_DEV=1 it has one bit per device.
- R9: A write (`deb_we_i`) sets the debounce pair from `deb_code_i`: 0 sets both low, 1 sets `deb_b_o` only, 2 sets `deb_a_o` only, and 3 sets both. With DEB_PER_DEV=1 only the pair of device `deb_dev_i` changes; with DEB_PER_DEV=0 one shared pair changes whatever `deb_dev_i` holds. The new value appears one edge after the write.
- R10: After reset `cs_n_o`=1, `sclk_o`=0, `done_o`=0, and all result, flag and debounce outputs are zero. Results hold their values between done pulses. Fault pins are sampled in the cycle just before `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Request a chain readout |
| wide_mode_i | input | 1 | 1 = status mode (two bytes per device), 0 = plain mode |
| ign_uv_i | input | 1 | Ignore undervoltage flags and fault pins |
| fault_pin_i | input | FAULT_PER_DEV ? N_DEV : 1 | Fault pins, active high |
| deb_we_i | input | 1 | Debounce write strobe |
| deb_dev_i | input | clog2(N_DEV) | Device selected by a debounce write |
| deb_code_i | input | 2 | Debounce setting code |
| miso_i | input | 1 | Serial data from the chain |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle result strobe |
| in_vec_o | output | 8·N_DEV | Input bits of all devices |
| crc_err_o | output | N_DEV | CRC mismatch per device |
| ot_o | output | N_DEV | Overtemperature per device |
| uv_alarm_o | output | N_DEV | Undervoltage alarm per device |
| uv_warn_o | output | N_DEV | Undervoltage warning per device |
| dev_bad_o | output | N_DEV | Faulting device mask |
| deb_a_o | output | DEB_PER_DEV ? N_DEV : 1 | First debounce select line |
| deb_b_o | output | DEB_PER_DEV ? N_DEV : 1 | Second debounce select line |

## Verification
Every result of a readout is due at the same edge: 2·B·CLK_DIV+1 edges after the edge that took the start. The bench counts edges from that point and samples at the falling clock edge after the strobe. It checks the count itself, and then compares the vector and all flag vectors against values computed from the transmitted bytes and pins. One edge later it checks that the strobe has dropped and that the vector held. Debounce outputs are due one edge after the write and are sampled at the next falling edge. A start pulsed mid-burst must leave both the edge count and the idle state after the burst unchanged.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        RD_IDLE,
        RD_LEAD,
        RD_HIGH,
        RD_LOW,
        RD_EVAL
    } rd_state_e;

    // Debounce setting codes: bit 1 drives line A, bit 0 drives line B
    typedef enum logic [1:0] {
        DEB_OFF   = 2'd0,
        DEB_SHORT = 2'd1,
        DEB_MID   = 2'd2,
        DEB_LONG  = 2'd3
    } deb_code_e;

    // Decoded per-device diagnosis
    typedef struct packed {
        logic crc_err;
        logic hot;
        logic uv_alarm;
        logic uv_warn;
        logic bad;
    } dev_flags_t;

    // x^5 + x^4 + x^2 + 1
    localparam logic [5:0] CRC5_GEN = 6'b110101;

endpackage

// File: rtl/chain_spi_seq.sv
module chain_spi_seq
    import chain_rd_pkg::*;
#(
    parameter int N_DEV   = 4,
    parameter int CLK_DIV = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 wide_i,
    input  logic                 ign_i,
    input  logic                 miso_i,
    output logic                 cs_n_o,
    output logic                 sclk_o,
    output logic                 busy_o,
    output logic                 eval_o,
    output logic                 wide_o,
    output logic                 ign_o,
    output logic [16*N_DEV-1:0]  shreg_o
);

    localparam int SHW  = 16 * N_DEV;
    localparam int CNTW = $clog2(SHW + 1);
    localparam int DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIVW-1:0] DIV_LAST    = DIVW'(CLK_DIV - 1);
    localparam logic [CNTW-1:0] BITS_WIDE   = CNTW'(SHW);
    localparam logic [CNTW-1:0] BITS_NARROW = CNTW'(8 * N_DEV);

    rd_state_e       state_q, state_d;
    logic [DIVW-1:0] div_q;
    logic [CNTW-1:0] left_q;
    logic [SHW-1:0]  sh_q;
    logic            wide_q, ign_q, cs_n_q, sclk_q;
    logic            phase_end, enter_high, accept;

    assign phase_end  = (div_q == DIV_LAST);
    assign accept     = (state_q == RD_IDLE) && start_i;
    assign enter_high = (state_d == RD_HIGH) && (state_q != RD_HIGH);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (start_i)   state_d = RD_LEAD;
            RD_LEAD: if (phase_end) state_d = RD_HIGH;
            RD_HIGH: if (phase_end) state_d = (left_q == '0) ? RD_EVAL : RD_LOW;
            RD_LOW:  if (phase_end) state_d = RD_HIGH;
            RD_EVAL:                state_d = RD_IDLE;
            default:                state_d = RD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            left_q <= '0;
            sh_q   <= '0;
            wide_q <= 1'b0;
            ign_q  <= 1'b0;
            cs_n_q <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            if (state_q == RD_IDLE || state_d != state_q) div_q <= '0;
            else                                          div_q <= div_q + DIVW'(1);

            if (accept) begin
                cs_n_q <= 1'b0;
                wide_q <= wide_i;
                ign_q  <= ign_i;
                left_q <= wide_i ? BITS_WIDE : BITS_NARROW;
                sh_q   <= '0;
            end

            if (enter_high) begin
                sclk_q <= 1'b1;
                sh_q   <= {sh_q[SHW-2:0], miso_i};
                left_q <= left_q - CNTW'(1);
            end

            if (state_q == RD_HIGH && phase_end) sclk_q <= 1'b0;

            if (state_d == RD_EVAL && state_q != RD_EVAL) cs_n_q <= 1'b1;
        end
    end

    assign cs_n_o  = cs_n_q;
    assign sclk_o  = sclk_q;
    assign busy_o  = (state_q != RD_IDLE);
    assign eval_o  = (state_q == RD_EVAL);
    assign wide_o  = wide_q;
    assign ign_o   = ign_q;
    assign shreg_o = sh_q;

endmodule

// File: rtl/chain_dev_decode.sv
module chain_dev_decode
    import chain_rd_pkg::*;
(
    input  logic       wide_i,
    input  logic       ign_i,
    input  logic       pin_i,
    input  logic [7:0] data_i,
    input  logic [7:0] stat_i,
    output dev_flags_t flags_o
);

    function automatic logic [4:0] crc5_of(input logic [7:0] d);
        logic [4:0] c;
        logic       fb;
        c = '0;
        for (int b = 7; b >= 0; b--) begin
            fb = c[4] ^ d[b];
            c  = {c[3:0], 1'b0};
            if (fb) c = c ^ CRC5_GEN[4:0];
        end
        return c;
    endfunction

    logic crc_bad, f_crc, f_hot, f_uva, f_uvw, f_pin;

    always_comb begin
        crc_bad = (stat_i[7:3] != crc5_of(data_i));
        f_crc   = wide_i & crc_bad;
        f_hot   = wide_i & stat_i[1];
        f_uva   = wide_i & ~ign_i & ~stat_i[2];
        f_uvw   = wide_i & ~ign_i & ~stat_i[0];
        f_pin   = ~ign_i & pin_i;
        flags_o.crc_err  = f_crc;
        flags_o.hot      = f_hot;
        flags_o.uv_alarm = f_uva;
        flags_o.uv_warn  = f_uvw;
        flags_o.bad      = f_pin | f_crc | f_hot | f_uva;
    end

endmodule

// File: rtl/chain_deb_regs.sv
module chain_deb_regs #(
    parameter int N_DEV   = 4,
    parameter int PER_DEV = 1,
    parameter int IDXW    = 2,
    parameter int DBW     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [IDXW-1:0] dev_i,
    input  logic [1:0]      code_i,
    output logic [DBW-1:0]  deb_a_o,
    output logic [DBW-1:0]  deb_b_o
);

    logic [DBW-1:0] sel;

    generate
        if (PER_DEV != 0) begin : g_per
            for (genvar j = 0; j < DBW; j++) begin : g_sel
                assign sel[j] = (dev_i == IDXW'(j));
            end
        end else begin : g_shared
            logic unused_dev;
            assign unused_dev = ^dev_i;
            assign sel = '1;
        end
    endgenerate

    for (genvar j = 0; j < DBW; j++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                deb_a_o[j] <= 1'b0;
                deb_b_o[j] <= 1'b0;
            end else if (we_i && sel[j]) begin
                deb_a_o[j] <= code_i[1];
                deb_b_o[j] <= code_i[0];
            end
        end
    end

endmodule

// File: rtl/chain_reader.sv
module chain_reader
    import chain_rd_pkg::*;
#(
    parameter int N_DEV         = 4,
    parameter int CLK_DIV       = 2,
    parameter int FAULT_PER_DEV = 1,
    parameter int DEB_PER_DEV   = 1,
    localparam int IDXW = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int FPW  = (FAULT_PER_DEV != 0) ? N_DEV : 1,
    localparam int DBW  = (DEB_PER_DEV != 0) ? N_DEV : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               wide_mode_i,
    input  logic               ign_uv_i,
    input  logic [FPW-1:0]     fault_pin_i,
    input  logic               deb_we_i,
    input  logic [IDXW-1:0]    deb_dev_i,
    input  logic [1:0]         deb_code_i,
    input  logic               miso_i,
    output logic               cs_n_o,
    output logic               sclk_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [8*N_DEV-1:0] in_vec_o,
    output logic [N_DEV-1:0]   crc_err_o,
    output logic [N_DEV-1:0]   ot_o,
    output logic [N_DEV-1:0]   uv_alarm_o,
    output logic [N_DEV-1:0]   uv_warn_o,
    output logic [N_DEV-1:0]   dev_bad_o,
    output logic [DBW-1:0]     deb_a_o,
    output logic [DBW-1:0]     deb_b_o
);

    localparam int SHW = 16 * N_DEV;

    logic           eval, wide_q, ign_q;
    logic [SHW-1:0] sh;
    logic [7:0]     dev_data [N_DEV];
    dev_flags_t     flg      [N_DEV];

    chain_spi_seq #(
        .N_DEV   (N_DEV),
        .CLK_DIV (CLK_DIV)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .wide_i  (wide_mode_i),
        .ign_i   (ign_uv_i),
        .miso_i  (miso_i),
        .cs_n_o  (cs_n_o),
        .sclk_o  (sclk_o),
        .busy_o  (busy_o),
        .eval_o  (eval),
        .wide_o  (wide_q),
        .ign_o   (ign_q),
        .shreg_o (sh)
    );

    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
        logic [7:0] stat_b;
        logic       pin;

        // first byte received lands in the top of the shift register
        assign dev_data[i] = wide_q ? sh[(2*N_DEV-1-2*i)*8 +: 8]
                                    : sh[(N_DEV-1-i)*8 +: 8];
        assign stat_b      = sh[(2*N_DEV-2-2*i)*8 +: 8];

        if (FAULT_PER_DEV != 0) begin : g_pin_own
            assign pin = fault_pin_i[i];
        end else begin : g_pin_shared
            assign pin = fault_pin_i[0];
        end

        chain_dev_decode u_dec (
            .wide_i  (wide_q),
            .ign_i   (ign_q),
            .pin_i   (pin),
            .data_i  (dev_data[i]),
            .stat_i  (stat_b),
            .flags_o (flg[i])
        );
    end

    // Result registers, loaded in the EVAL cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            in_vec_o   <= '0;
            crc_err_o  <= '0;
            ot_o       <= '0;
            uv_alarm_o <= '0;
            uv_warn_o  <= '0;
            dev_bad_o  <= '0;
        end else begin
            done_o <= eval;
            if (eval) begin
                for (int i = 0; i < N_DEV; i++) begin
                    in_vec_o[i*8 +: 8] <= dev_data[i];
                    crc_err_o[i]       <= flg[i].crc_err;
                    ot_o[i]            <= flg[i].hot;
                    uv_alarm_o[i]      <= flg[i].uv_alarm;
                    uv_warn_o[i]       <= flg[i].uv_warn;
                    dev_bad_o[i]       <= flg[i].bad;
                end
            end
        end
    end

    chain_deb_regs #(
        .N_DEV   (N_DEV),
        .PER_DEV (DEB_PER_DEV),
        .IDXW    (IDXW),
        .DBW     (DBW)
    ) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (deb_we_i),
        .dev_i   (deb_dev_i),
        .code_i  (deb_code_i),
        .deb_a_o (deb_a_o),
        .deb_b_o (deb_b_o)
    );

endmodule

// File: rtl/chain_reader_chk.sv
module chain_reader_chk #(
    parameter int N_DEV   = 4,
    parameter int CLK_DIV = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               cs_n_o,
    input logic               sclk_o,
    input logic               busy_o,
    input logic               done_o,
    input logic [8*N_DEV-1:0] in_vec_o,
    input logic [N_DEV-1:0]   crc_err_o,
    input logic [N_DEV-1:0]   ot_o,
    input logic [N_DEV-1:0]   uv_alarm_o,
    input logic [N_DEV-1:0]   dev_bad_o
);

    // R1: clock stays low while the chain is deselected
    a_r1_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R1: chip select only falls after a start seen while idle
    a_r1_cs_fall_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o)));

    // R1: idle means deselected
    a_r1_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);

    // R2: the done strobe lasts one cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: a high phase lasts more than one cycle when the divider allows it
    generate
        if (CLK_DIV > 1) begin : g_hold
            a_r2_sclk_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(sclk_o) |=> sclk_o);
        end
    endgenerate

    // R10: results only move with the strobe
    a_r10_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(in_vec_o));

    // R7: every hard status fault marks the device bad
    a_r7_bad_covers_status: assert property (@(posedge clk) disable iff (!rst_n)
        ((crc_err_o | ot_o | uv_alarm_o) & ~dev_bad_o) == '0);

endmodule

bind chain_reader chain_reader_chk #(
    .N_DEV   (N_DEV),
    .CLK_DIV (CLK_DIV)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .in_vec_o   (in_vec_o),
    .crc_err_o  (crc_err_o),
    .ot_o       (ot_o),
    .uv_alarm_o (uv_alarm_o),
    .dev_bad_o  (dev_bad_o)
);

// File: tb/tb_chain_reader.sv
`timescale 1ns/1ps
module tb_chain_reader;

    localparam int N   = 4;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic           start = 1'b0, wide = 1'b0, ign = 1'b0;
    logic [N-1:0]   pins = '0;
    logic           shpin = 1'b0;
    logic           deb_we = 1'b0;
    logic [1:0]     deb_dev = '0, deb_code = '0;
    logic           miso;

    logic           cs_n, sclk, busy, done;
    logic [8*N-1:0] in_vec;
    logic [N-1:0]   crc_err, ot, uva, uvw, bad, deb_a, deb_b;

    logic           s_cs_n, s_sclk, s_busy, s_done;
    logic [8*N-1:0] s_vec;
    logic [N-1:0]   s_crc, s_ot, s_uva, s_uvw, s_bad;
    logic           s_deb_a, s_deb_b;

    chain_reader #(.N_DEV(N), .CLK_DIV(DIV), .FAULT_PER_DEV(1), .DEB_PER_DEV(1)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .wide_mode_i(wide), .ign_uv_i(ign),
        .fault_pin_i(pins), .deb_we_i(deb_we), .deb_dev_i(deb_dev), .deb_code_i(deb_code),
        .miso_i(miso), .cs_n_o(cs_n), .sclk_o(sclk), .busy_o(busy), .done_o(done),
        .in_vec_o(in_vec), .crc_err_o(crc_err), .ot_o(ot), .uv_alarm_o(uva),
        .uv_warn_o(uvw), .dev_bad_o(bad), .deb_a_o(deb_a), .deb_b_o(deb_b));

    chain_reader #(.N_DEV(N), .CLK_DIV(DIV), .FAULT_PER_DEV(0), .DEB_PER_DEV(0)) dut_sh (
        .clk(clk), .rst_n(rst_n), .start_i(start), .wide_mode_i(wide), .ign_uv_i(ign),
        .fault_pin_i(shpin), .deb_we_i(deb_we), .deb_dev_i(deb_dev), .deb_code_i(deb_code),
        .miso_i(miso), .cs_n_o(s_cs_n), .sclk_o(s_sclk), .busy_o(s_busy), .done_o(s_done),
        .in_vec_o(s_vec), .crc_err_o(s_crc), .ot_o(s_ot), .uv_alarm_o(s_uva),
        .uv_warn_o(s_uvw), .dev_bad_o(s_bad), .deb_a_o(s_deb_a), .deb_b_o(s_deb_b));

    // Chain model: a new bit after each SCLK fall, first bit ready at select
    logic [16*N-1:0] stream = '0;
    int nbits = 8;
    int idx = 0;
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) idx = 0;
        else      idx = idx + 1;
    end
    assign miso = (idx < nbits) ? stream[nbits-1-idx] : 1'b0;

    logic [7:0] ib [N];
    logic [7:0] sb [N];

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Polynomial division by x^5+x^4+x^2+1
    function automatic logic [4:0] ref_crc5(input logic [7:0] d);
        logic [12:0] r;
        r = {d, 5'b0};
        for (int b = 12; b >= 5; b--)
            if (r[b]) r[b -: 6] = r[b -: 6] ^ 6'b110101;
        return r[4:0];
    endfunction

    function automatic logic [7:0] good_stat(input logic [7:0] d);
        return {ref_crc5(d), 3'b101};
    endfunction

    task automatic run_burst(input logic w, input logic ig, input logic [N-1:0] p,
                             input logic sp, input bit poke);
        int cyc, bytes;
        logic [63:0] held;
        logic [8*N-1:0] ev;
        logic [N-1:0] ec, eo, ea, ew, eb, ebs;
        bytes = w ? 2*N : N;
        nbits = bytes * 8;
        stream = '0;
        for (int i = 0; i < N; i++) begin
            if (w) begin
                stream[(bytes-1-2*i)*8 +: 8] = ib[i];
                stream[(bytes-2-2*i)*8 +: 8] = sb[i];
            end else begin
                stream[(bytes-1-i)*8 +: 8] = ib[i];
            end
        end
        @(negedge clk);
        wide = w; ign = ig; pins = p; shpin = sp; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (done !== 1'b1 && cyc < 4000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = (poke && cyc == 20);
        end
        start = 1'b0;
        chk("R2", "cycles to done", 64'(cyc), 64'(2*nbits*DIV+1));
        for (int i = 0; i < N; i++) begin
            ev[i*8 +: 8] = ib[i];
            ec[i]  = w && (sb[i][7:3] != ref_crc5(ib[i]));
            eo[i]  = w && sb[i][1];
            ea[i]  = w && !ig && !sb[i][2];
            ew[i]  = w && !ig && !sb[i][0];
            eb[i]  = (!ig && p[i]) || ec[i] || eo[i] || ea[i];
            ebs[i] = (!ig && sp) || ec[i] || eo[i] || ea[i];
        end
        chk("R3", "input vector", 64'(in_vec), 64'(ev));
        chk("R4", "crc error", 64'(crc_err), 64'(ec));
        chk("R5", "overtemp", 64'(ot), 64'(eo));
        chk(ig ? "R6" : "R5", "uv alarm", 64'(uva), 64'(ea));
        chk(ig ? "R6" : "R5", "uv warn", 64'(uvw), 64'(ew));
        chk(ig ? "R6" : "R7", "bad mask", 64'(bad), 64'(eb));
        chk("R8", "shared-pin bad mask", 64'(s_bad), 64'(ebs));
        held = 64'(in_vec);
        @(posedge clk);
        @(negedge clk);
        chk("R2", "done width", 64'(done), 64'd0);
        chk("R10", "vector held", 64'(in_vec), held);
        if (poke) begin
            repeat (8) @(negedge clk);
            chk("R1", "no second burst (cs_n)", 64'(cs_n), 64'd1);
            chk("R1", "no second burst (busy)", 64'(busy), 64'd0);
        end
    endtask

    task automatic deb_write(input logic [1:0] dv, input logic [1:0] cd,
                             input logic [N-1:0] ea, input logic [N-1:0] eb,
                             input logic sa, input logic sbv);
        @(negedge clk);
        deb_we = 1'b1; deb_dev = dv; deb_code = cd;
        @(negedge clk);
        deb_we = 1'b0;
        chk("R9", "debounce line A", 64'(deb_a), 64'(ea));
        chk("R9", "debounce line B", 64'(deb_b), 64'(eb));
        chk("R9", "shared line A", 64'(s_deb_a), 64'(sa));
        chk("R9", "shared line B", 64'(s_deb_b), 64'(sbv));
    endtask

    // Watchdog
    initial begin
        #(150000 * 5);
        nchk++;
        nerr++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset cs_n", 64'(cs_n), 64'd1);
        chk("R10", "reset sclk", 64'(sclk), 64'd0);
        chk("R10", "reset done", 64'(done), 64'd0);
        chk("R10", "reset vector", 64'(in_vec), 64'd0);
        chk("R10", "reset bad", 64'(bad), 64'd0);
        chk("R10", "reset debounce", 64'({deb_a, deb_b}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // plain mode: status bytes not sent, only pins diagnose
        ib[0] = 8'hA5; ib[1] = 8'h3C; ib[2] = 8'h0F; ib[3] = 8'hF0;
        for (int i = 0; i < N; i++) sb[i] = 8'h00;
        run_burst(1'b0, 1'b0, 4'b0000, 1'b0, 1'b0);
        run_burst(1'b0, 1'b0, 4'b0100, 1'b1, 1'b0);

        // status mode, all healthy
        for (int i = 0; i < N; i++) sb[i] = good_stat(ib[i]);
        run_burst(1'b1, 1'b0, 4'b0000, 1'b0, 1'b0);

        // one fault kind per device: warn, crc, overtemp, alarm
        sb[0] = good_stat(ib[0]) & 8'hFE;
        sb[1] = good_stat(ib[1]) ^ 8'h08;
        sb[2] = good_stat(ib[2]) | 8'h02;
        sb[3] = good_stat(ib[3]) & 8'hFB;
        run_burst(1'b1, 1'b0, 4'b0000, 1'b0, 1'b0);
        // ignore undervoltage with all pins asserted
        run_burst(1'b1, 1'b1, 4'b1111, 1'b1, 1'b0);

        // start pulsed mid-burst
        for (int i = 0; i < N; i++) sb[i] = good_stat(ib[i]);
        run_burst(1'b1, 1'b0, 4'b0010, 1'b0, 1'b1);

        // debounce register (R9)
        deb_write(2'd2, 2'd2, 4'b0100, 4'b0000, 1'b1, 1'b0);
        deb_write(2'd0, 2'd1, 4'b0100, 4'b0001, 1'b0, 1'b1);
        deb_write(2'd3, 2'd3, 4'b1100, 4'b1001, 1'b1, 1'b1);
        deb_write(2'd2, 2'd0, 4'b1000, 4'b1001, 1'b0, 1'b0);

        // random bursts
        for (int n = 0; n < 24; n++) begin
            logic w, ig, sp;
            logic [N-1:0] p;
            for (int i = 0; i < N; i++) begin
                ib[i] = 8'($urandom);
                sb[i] = good_stat(ib[i]);
                if ($urandom % 5 == 0) sb[i] = sb[i] ^ (8'h08 << ($urandom % 5));
                if ($urandom % 3 == 0) sb[i][2:0] = 3'($urandom);
            end
            w  = 1'($urandom);
            ig = ($urandom % 4 == 0);
            p  = 4'($urandom) & 4'($urandom);
            sp = ($urandom % 4 == 0);
            run_burst(w, ig, p, sp, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule